// File: doc/BRIEF.md
# Pin Function Multiplexer with GPIO

This block owns a bank of device pins grouped in collections of eight. Each pin is either a general-purpose I/O that software controls directly, or handed over to one of three peripheral clients. The pin's output-enable and output level then follow that client's signals. Software programs the block through a byte-wide register port. Each pin has a 2-bit function code, a drive-enable bit and an output-level bit. Software can also read the pin's level, which is brought into the clock domain by two flops.

Every collection has an 8-byte window in the address map. The function codes of a collection are packed four pins to a byte across two bytes. The drive, output and input bytes follow. Register writes are captured on the rising clock edge at which the write strobe is high. Reads are combinational from the addressed byte, so register and status values can be polled without a wait state.

Top module: `pinmux_top`

## Requirements
- R1: After reset every function code, drive bit and output bit is zero, so every pin is a GPIO input (padOe all zero) and the function, drive and output bytes of every collection read back 0x00.
- R2: Collection c (0 to NUM_COLL-1) occupies byte addresses BASE_ADDR + 8*c to BASE_ADDR + 8*c + 7 (default BASE_ADDR = 0x20, 18 collections). Bit i of a collection byte, or bit pair i, belongs to pin 8*c + i.
- R3: Function codes are 2 bits per pin. Pins 0 to 3 of a collection sit in byte offset +0 at bits [2i+1:2i]. Pins 4 to 7 sit in byte offset +1 at bits [2(i-4)+1:2(i-4)]. Both bytes read back what was written.
- R4: A pin with function code 0 drives padOe from its bit in the drive byte (offset +2, 1 = output) and padOut from its bit in the output byte (offset +3).
- R5: A pin with function code 1, 2 or 3 takes padOe and padOut from client A, B or C respectively, whatever its drive and output bits hold.
- R6: The input byte (offset +6) returns the padIn level of each pin after two flop stages. A level applied before a rising edge is visible after the second rising edge, and not after the first.
- R7: Offsets +4, +5 and +7, and addresses below BASE_ADDR or at and above BASE_ADDR + 8*NUM_COLL, read as 0x00, and writes to them change no state. A write to the input byte has no effect.
- R8: A write is applied on the rising edge at which regWe is high. Before that edge the addressed byte reads its old value, and right after it the byte reads the new one, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| padIn | input | NUM_COLL*8 | Level seen at each pin |
| padOe | output | NUM_COLL*8 | Output enable to each pin |
| padOut | output | NUM_COLL*8 | Output level to each pin |
| cliAOe | input | NUM_COLL*8 | Client A output enable per pin |
| cliAOut | input | NUM_COLL*8 | Client A output level per pin |
| cliBOe | input | NUM_COLL*8 | Client B output enable per pin |
| cliBOut | input | NUM_COLL*8 | Client B output level per pin |
| cliCOe | input | NUM_COLL*8 | Client C output enable per pin |
| cliCOut | input | NUM_COLL*8 | Client C output level per pin |

## Verification
Several properties are checked on every cycle:
- No write strobe is raised without regWe or towards the input byte.
- The function, drive and output state does not move without its own strobe.
- The input byte lags padIn by exactly two edges.
- Addresses outside the window read zero.

Other behaviour can only be shown by the bench's scenarios:
- The bit packing of the function codes across the two bytes.
- The routing of each pin to the right client or to its GPIO bits.
- The first-edge-versus-second-edge visibility of an input change.
- Write-then-read timing around the edge.
- Recovery from a reset applied mid-run.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  typedef enum logic [2:0] {
    RD_NONE   = 3'd0,
    RD_SEL_LO = 3'd1,
    RD_SEL_HI = 3'd2,
    RD_DRV    = 3'd3,
    RD_OUT    = 3'd4,
    RD_IN     = 3'd5
  } regKind_e;

  typedef struct packed {
    logic       wrSelLo;
    logic       wrSelHi;
    logic       wrDrv;
    logic       wrOut;
    regKind_e   rdKind;
    logic [7:0] wdata;
  } strobe_t;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_COLL  = 18,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32,
  localparam int COLL_W   = (NUM_COLL > 1) ? $clog2(NUM_COLL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output strobe_t           strb,
  output logic [COLL_W-1:0] collIdx
);
  localparam logic [ADDR_W:0] BASE_L = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] END_L  = (ADDR_W+1)'(BASE_ADDR + 8*NUM_COLL);

  logic [ADDR_W:0] addrExt;
  logic [ADDR_W:0] relOff;
  logic            inRange;
  regKind_e        kind;

  always_comb begin
    addrExt = {1'b0, regAddr};
    relOff  = addrExt - BASE_L;
    inRange = (addrExt >= BASE_L) && (addrExt < END_L);
    collIdx = COLL_W'(relOff >> 3);
    kind    = RD_NONE;
    if (inRange) begin
      unique case (relOff[2:0])
        3'd0:    kind = RD_SEL_LO;
        3'd1:    kind = RD_SEL_HI;
        3'd2:    kind = RD_DRV;
        3'd3:    kind = RD_OUT;
        3'd6:    kind = RD_IN;
        default: kind = RD_NONE;
      endcase
    end
    strb.rdKind  = kind;
    strb.wdata   = regWdata;
    strb.wrSelLo = regWe && (kind == RD_SEL_LO);
    strb.wrSelHi = regWe && (kind == RD_SEL_HI);
    strb.wrDrv   = regWe && (kind == RD_DRV);
    strb.wrOut   = regWe && (kind == RD_OUT);
  end

  // R8
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> !(strb.wrSelLo || strb.wrSelHi || strb.wrDrv || strb.wrOut));

  // R7
  input_byte_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_IN) |-> !(strb.wrSelLo || strb.wrSelHi || strb.wrDrv || strb.wrOut));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSelLo, strb.wrSelHi, strb.wrDrv, strb.wrOut}));
endmodule

// File: rtl/pinmux_dp.sv
module pinmux_dp
  import pinmux_pkg::*;
#(
  parameter int NUM_COLL = 18,
  localparam int NPINS   = NUM_COLL * 8,
  localparam int COLL_W  = (NUM_COLL > 1) ? $clog2(NUM_COLL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COLL_W-1:0] collIdx,
  output logic [7:0]        rdByte,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padOut,
  input  logic [NPINS-1:0]  cliAOe,
  input  logic [NPINS-1:0]  cliAOut,
  input  logic [NPINS-1:0]  cliBOe,
  input  logic [NPINS-1:0]  cliBOut,
  input  logic [NPINS-1:0]  cliCOe,
  input  logic [NPINS-1:0]  cliCOut
);
  logic [2*NPINS-1:0] selQ;
  logic [NPINS-1:0]   drvQ;
  logic [NPINS-1:0]   outQ;
  logic [NPINS-1:0]   sync1Q;
  logic [NPINS-1:0]   sync2Q;
  logic [1:0]         ageQ;
  int unsigned        selBase;
  int unsigned        bitBase;

  always_comb begin
    selBase = 16 * int'(collIdx);
    bitBase = 8 * int'(collIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      drvQ <= '0;
      outQ <= '0;
    end else begin
      if (strb.wrSelLo) selQ[selBase +: 8]     <= strb.wdata;
      if (strb.wrSelHi) selQ[selBase + 8 +: 8] <= strb.wdata;
      if (strb.wrDrv)   drvQ[bitBase +: 8]     <= strb.wdata;
      if (strb.wrOut)   outQ[bitBase +: 8]     <= strb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      ageQ   <= '0;
    end else begin
      sync1Q <= padIn;
      sync2Q <= sync1Q;
      if (ageQ != 2'd3) ageQ <= ageQ + 2'd1;
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_SEL_LO: rdByte = selQ[selBase +: 8];
      RD_SEL_HI: rdByte = selQ[selBase + 8 +: 8];
      RD_DRV:    rdByte = drvQ[bitBase +: 8];
      RD_OUT:    rdByte = outQ[bitBase +: 8];
      RD_IN:     rdByte = sync2Q[bitBase +: 8];
      default:   rdByte = 8'h00;
    endcase
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [1:0] fn;
    assign fn = selQ[2*g +: 2];
    always_comb begin
      unique case (fn)
        2'd0: begin padOe[g] = drvQ[g];   padOut[g] = outQ[g];    end
        2'd1: begin padOe[g] = cliAOe[g]; padOut[g] = cliAOut[g]; end
        2'd2: begin padOe[g] = cliBOe[g]; padOut[g] = cliBOut[g]; end
        default: begin padOe[g] = cliCOe[g]; padOut[g] = cliCOut[g]; end
      endcase
    end
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrSelLo || strb.wrSelHi) |=> $stable(selQ));

  // R4
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDrv |=> $stable(drvQ));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrOut |=> $stable(outQ));

  // R6
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ageQ >= 2'd2) |-> (sync2Q == $past(padIn, 2)));
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_COLL  = 18,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32,
  localparam int NPINS    = NUM_COLL * 8,
  localparam int COLL_W   = (NUM_COLL > 1) ? $clog2(NUM_COLL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padOut,
  input  logic [NPINS-1:0]  cliAOe,
  input  logic [NPINS-1:0]  cliAOut,
  input  logic [NPINS-1:0]  cliBOe,
  input  logic [NPINS-1:0]  cliBOut,
  input  logic [NPINS-1:0]  cliCOe,
  input  logic [NPINS-1:0]  cliCOut
);
  localparam logic [ADDR_W:0] BASE_L = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] END_L  = (ADDR_W+1)'(BASE_ADDR + 8*NUM_COLL);

  strobe_t           strb;
  logic [COLL_W-1:0] collIdx;

  pinmux_ctrl #(.NUM_COLL(NUM_COLL), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .strb(strb), .collIdx(collIdx)
  );

  pinmux_dp #(.NUM_COLL(NUM_COLL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .collIdx(collIdx), .rdByte(regRdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .cliAOe(cliAOe), .cliAOut(cliAOut), .cliBOe(cliBOe), .cliBOut(cliBOut),
    .cliCOe(cliCOe), .cliCOut(cliCOut)
  );

  // R7
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (({1'b0, regAddr} < BASE_L) || ({1'b0, regAddr} >= END_L)) |-> (regRdata == 8'h00));
endmodule

// File: tb/tb_pinmux_top.sv
module tb_pinmux_top;
  localparam int NUM_COLL = 18;
  localparam int ADDR_W   = 8;
  localparam int BASE     = 32;
  localparam int NPINS    = NUM_COLL * 8;
  localparam int NVEC     = 12;

  // {address, write data, expected read-back}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h20_E4_E4, 24'h21_1B_1B, 24'h22_A5_A5, 24'h23_3C_3C,
    24'h24_FF_00, 24'h25_FF_00, 24'h27_FF_00, 24'hA8_55_55,
    24'hAB_81_81, 24'hB0_FF_00, 24'h1F_FF_00, 24'h31_C6_C6
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic [7:0]        regWdata = '0;
  logic [7:0]        regRdata;
  logic [NPINS-1:0]  padIn = '0;
  logic [NPINS-1:0]  padOe, padOut;
  logic [NPINS-1:0]  cliAOe = '0, cliAOut = '0, cliBOe = '0, cliBOut = '0;
  logic [NPINS-1:0]  cliCOe = '0, cliCOut = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [1:0]       selSh [NPINS];
  logic [NPINS-1:0] drvSh, outSh;

  always #4 clk = ~clk;

  pinmux_top #(.NUM_COLL(NUM_COLL), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .cliAOe(cliAOe), .cliAOut(cliAOut), .cliBOe(cliBOe), .cliBOut(cliBOut),
    .cliCOe(cliCOe), .cliCOut(cliCOut)
  );

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chkV(string req, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearShadow();
    for (int p = 0; p < NPINS; p++) selSh[p] = 2'd0;
    drvSh = '0;
    outSh = '0;
  endtask

  task automatic shadowWrite(int addr, logic [7:0] d);
    int c, o;
    if (addr >= BASE && addr < BASE + 8*NUM_COLL) begin
      c = (addr - BASE) / 8;
      o = (addr - BASE) % 8;
      if (o == 0) for (int i = 0; i < 4; i++) selSh[c*8+i] = d[2*i +: 2];
      if (o == 1) for (int i = 4; i < 8; i++) selSh[c*8+i] = d[2*(i-4) +: 2];
      if (o == 2) drvSh[c*8 +: 8] = d;
      if (o == 3) outSh[c*8 +: 8] = d;
    end
  endtask

  task automatic wr(int addr, logic [7:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(addr);
    regWdata = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    shadowWrite(addr, d);
  endtask

  task automatic rd(int addr, output logic [7:0] d);
    regAddr = ADDR_W'(addr);
    #1;
    d = regRdata;
  endtask

  task automatic checkPads(string req);
    logic [NPINS-1:0] eOe, eOut;
    for (int p = 0; p < NPINS; p++) begin
      case (selSh[p])
        2'd0: begin eOe[p] = drvSh[p];  eOut[p] = outSh[p];  end
        2'd1: begin eOe[p] = cliAOe[p]; eOut[p] = cliAOut[p]; end
        2'd2: begin eOe[p] = cliBOe[p]; eOut[p] = cliBOut[p]; end
        default: begin eOe[p] = cliCOe[p]; eOut[p] = cliCOut[p]; end
      endcase
    end
    #1;
    chkV({req, " padOe"}, padOe, eOe);
    chkV({req, " padOut"}, padOut, eOut);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    clearShadow();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkV("R1 padOe after reset", padOe, '0);
    rd(BASE + 8*5 + 0, r); chk8("R1 sel lo reset", r, 8'h00);
    rd(BASE + 8*5 + 1, r); chk8("R1 sel hi reset", r, 8'h00);
    rd(BASE + 8*5 + 2, r); chk8("R1 drive reset", r, 8'h00);
    rd(BASE + 8*5 + 3, r); chk8("R1 output reset", r, 8'h00);

    // R2 R3 R7: vector table of writes and read-backs
    for (int v = 0; v < NVEC; v++) begin
      wr(int'(VEC[v][23:16]), VEC[v][15:8]);
      rd(int'(VEC[v][23:16]), r);
      chk8($sformatf("R2/R3/R7 vec %0d", v), r, VEC[v][7:0]);
    end

    // R4 R5: routing with two client patterns
    cliAOe = {18{8'h96}}; cliAOut = {18{8'h5A}};
    cliBOe = {18{8'h3C}}; cliBOut = {18{8'hF0}};
    cliCOe = {18{8'hE1}}; cliCOut = {18{8'h0F}};
    checkPads("R4/R5 pattern1");
    cliAOe = ~cliAOe; cliBOut = ~cliBOut; cliCOe = {18{8'h77}};
    checkPads("R4/R5 pattern2");
    // R5: client pin ignores its gpio drive and output bits
    wr(BASE + 2, 8'h00);
    wr(BASE + 3, 8'hFF);
    checkPads("R5 client overrides gpio bits");

    // R7: writes to unmapped bytes and the input byte leave state alone
    wr(BASE + 8*1 + 6, 8'hFF);
    wr(BASE + 8*1 + 4, 8'hFF);
    wr(BASE + 8*NUM_COLL, 8'hFF);
    wr(BASE - 1, 8'hFF);
    checkPads("R7 ignored writes");
    rd(BASE + 8*1 + 6, r); chk8("R7 input byte not written", r, 8'h00);
    rd(BASE + 8*1 + 2, r); chk8("R7 drive byte untouched", r, 8'h00);

    // R6: two-stage input path
    @(negedge clk);
    padIn = {18{8'h00}};
    padIn[7:0] = 8'hC3;
    padIn[8*17 +: 8] = 8'h5E;
    @(negedge clk);
    rd(BASE + 6, r); chk8("R6 not visible after one edge", r, 8'h00);
    @(negedge clk);
    rd(BASE + 6, r); chk8("R6 visible after two edges", r, 8'hC3);
    rd(BASE + 8*17 + 6, r); chk8("R6 last collection input", r, 8'h5E);

    // R8: write visible right after its edge, not before
    @(negedge clk);
    regAddr = ADDR_W'(BASE + 8*1 + 2);
    regWdata = 8'hF0;
    regWe = 1'b1;
    #1;
    chk8("R8 old value before edge", regRdata, 8'h00);
    @(posedge clk);
    #1;
    chk8("R8 new value after edge", regRdata, 8'hF0);
    @(negedge clk);
    regWe = 1'b0;
    shadowWrite(BASE + 8*1 + 2, 8'hF0);
    checkPads("R8 pads after write");

    // R1: reset applied mid-run
    @(negedge clk);
    rstN = 1'b0;
    clearShadow();
    #1;
    chkV("R1 padOe in reset", padOe, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(BASE, r); chk8("R1 sel cleared by reset", r, 8'h00);
    rd(BASE + 8*17 + 3, r); chk8("R1 output cleared by reset", r, 8'h00);
    checkPads("R1 pads after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule